// File: doc/BRIEF.md
# Font Bit-to-Color Expander

This block converts monochrome glyph data into packed colour pixels. Software loads a 16-bit pattern of font bits and an 8-bit colour pair into two registers. The colour pair holds a foreground nibble in bits 7:4 and a background nibble in bits 3:0. Software then reads four result words from a window of consecutive word addresses. Each result word turns four font bits into four 4-bit pixels, so the 16 font bits become 64 bits of colour data.

The results are not stored anywhere. They come straight from combinational logic that works on the current register contents. A read always reflects the most recent completed write, and there is no buffer to keep coherent. Both word and byte reads are supported. A byte read returns the selected half of the word in bits 7:0 and leaves bits 15:8 at zero.

The byte address map is as follows. 0x0 is the colour register, with its value in bits 7:0; the upper byte reads as zero. 0x2 is the font register. 0x4 and 0x6 are unmapped and read as zero. 0x8, 0xA, 0xC and 0xE are the four result words.

Top module: `font_expander`

## Requirements
- R1: After reset, both source registers are zero, and every address reads as zero.
- R2: Each output pixel takes the colour register's bits 7:4 when its font bit is 1. It takes bits 3:0 when its font bit is 0.
- R3: The result word at byte offset 0x8 + 2k (k = 0..3) is built from font bits [15-4k : 12-4k]. Offset 0x8 therefore uses bits 15:12, and offset 0xE uses bits 3:0.
- R4: Within a group of four font bits, the lowest bit drives result bits 3:0 and the highest bit drives result bits 15:12. Each bit in between drives the nibble that matches its rank.
- R5: A byte read (byte_i=1) at an even address returns the upper byte of the addressed word in rd_data_o[7:0]. At an odd address it returns the lower byte. In both cases rd_data_o[15:8] is zero.
- R6: A word or byte write anywhere in the result window (0x8 to 0xF) leaves both source registers unchanged.
- R7: Results are computed at read time. A read in the cycle after a register write already shows the expansion of the new value.
- R8: Register writes work as follows. A word write to 0x0 loads the colour register from wdata[7:0], and a word write to 0x2 loads the font register from wdata[15:0]. A byte write takes its data from wdata[7:0]. At 0x1 it loads the colour register. At 0x2 it loads font bits 15:8, and at 0x3 it loads font bits 7:0. A byte write to 0x0 has no effect. The source registers change only on a write.
- R9: The unmapped words at 0x4 and 0x6 read as zero, and writes to them change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| addr_i | input | 4 | Byte address of the access |
| byte_i | input | 1 | 1 = byte access, 0 = word access |
| wr_i | input | 1 | Write strobe, sampled on the rising clock edge |
| wdata_i | input | 16 | Write data (byte writes use bits 7:0) |
| rd_data_o | output | 16 | Combinational read data for addr_i |

## Verification
The assertions take for granted that the bus inputs are known (never X) whenever reset is released. They also assume at most one access per cycle, and a write strobe that lasts a single clock edge per write. The stimulus meets these assumptions in three ways. It changes every input only on the falling clock edge and holds each access for exactly one cycle. It returns wr_i to zero between writes. It samples the combinational read data just after the rising edge, while the inputs are still steady.

// File: rtl/fx_pkg.sv
package fx_pkg;
  localparam int unsigned FX_DATA_W = 16;
  localparam int unsigned FX_COL_W  = 8;
  localparam int unsigned FX_NIB_W  = 4;
  localparam int unsigned FX_ADDR_W = 4;
  localparam int unsigned FX_GRP_W  = FX_DATA_W / FX_NIB_W;
  localparam int unsigned FX_N_GRP  = FX_DATA_W / FX_GRP_W;
  // word indices of the source registers
  localparam int unsigned FX_IDX_COLOR = 0;
  localparam int unsigned FX_IDX_FONT  = 1;
endpackage

// File: rtl/fx_regs.sv
module fx_regs #(
  parameter int unsigned ADDR_W = fx_pkg::FX_ADDR_W,
  parameter int unsigned DATA_W = fx_pkg::FX_DATA_W,
  parameter int unsigned COL_W  = fx_pkg::FX_COL_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              byte_i,
  input  logic              wr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [COL_W-1:0]  color_o,
  output logic [DATA_W-1:0] font_o
);
  localparam int unsigned IDX_W = ADDR_W - 1;
  localparam int unsigned HALF  = DATA_W / 2;

  logic [IDX_W-1:0] idx;
  logic             in_win;
  logic             wr_col, wr_font_hi, wr_font_lo;

  assign idx    = addr_i[ADDR_W-1:1];
  assign in_win = addr_i[ADDR_W-1];

  always_comb begin
    wr_col     = 1'b0;
    wr_font_hi = 1'b0;
    wr_font_lo = 1'b0;
    if (wr_i && !in_win) begin
      if (idx == IDX_W'(fx_pkg::FX_IDX_COLOR)) begin
        wr_col = !byte_i || addr_i[0];
      end else if (idx == IDX_W'(fx_pkg::FX_IDX_FONT)) begin
        wr_font_hi = !byte_i || !addr_i[0];
        wr_font_lo = !byte_i || addr_i[0];
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      color_o <= '0;
      font_o  <= '0;
    end else begin
      if (wr_col) color_o <= wdata_i[COL_W-1:0];
      if (wr_font_hi) font_o[DATA_W-1:HALF] <= byte_i ? wdata_i[HALF-1:0] : wdata_i[DATA_W-1:HALF];
      if (wr_font_lo) font_o[HALF-1:0] <= wdata_i[HALF-1:0];
    end
  end

  a_r6_window_write_ignored: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && addr_i[ADDR_W-1]) |=> ($stable(color_o) && $stable(font_o)));

  a_r8_hold_without_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_i |=> ($stable(color_o) && $stable(font_o)));

  a_r8_font_word_load: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && !byte_i && addr_i[ADDR_W-1:1] == IDX_W'(fx_pkg::FX_IDX_FONT))
    |=> (font_o == $past(wdata_i)));

  a_r8_byte_zero_ignored: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && byte_i && addr_i == '0) |=> ($stable(color_o) && $stable(font_o)));
endmodule

// File: rtl/fx_expand.sv
module fx_expand #(
  parameter int unsigned DATA_W = fx_pkg::FX_DATA_W,
  parameter int unsigned COL_W  = fx_pkg::FX_COL_W,
  parameter int unsigned NIB_W  = fx_pkg::FX_NIB_W
) (
  input  logic [COL_W-1:0]  color_i,
  input  logic [DATA_W-1:0] font_i,
  output logic [DATA_W/(DATA_W/NIB_W)-1:0][DATA_W-1:0] words_o
);
  localparam int unsigned GRP_W = DATA_W / NIB_W;
  localparam int unsigned N_GRP = DATA_W / GRP_W;

  logic [NIB_W-1:0] fg, bg;
  assign fg = color_i[COL_W-1 -: NIB_W];
  assign bg = color_i[NIB_W-1:0];

  for (genvar k = 0; k < N_GRP; k++) begin : g_word
    logic [GRP_W-1:0] grp;
    // word 0 takes the most significant group
    assign grp = font_i[DATA_W-1-k*GRP_W -: GRP_W];
    for (genvar j = 0; j < GRP_W; j++) begin : g_pix
      assign words_o[k][j*NIB_W +: NIB_W] = grp[j] ? fg : bg;
    end
  end
endmodule

// File: rtl/fx_rdmux.sv
module fx_rdmux #(
  parameter int unsigned ADDR_W = fx_pkg::FX_ADDR_W,
  parameter int unsigned DATA_W = fx_pkg::FX_DATA_W,
  parameter int unsigned COL_W  = fx_pkg::FX_COL_W,
  parameter int unsigned N_GRP  = fx_pkg::FX_N_GRP
) (
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              byte_i,
  input  logic [COL_W-1:0]  color_i,
  input  logic [DATA_W-1:0] font_i,
  input  logic [N_GRP-1:0][DATA_W-1:0] words_i,
  output logic [DATA_W-1:0] rd_data_o
);
  localparam int unsigned IDX_W = ADDR_W - 1;
  localparam int unsigned HALF  = DATA_W / 2;
  localparam int unsigned WIN_W = IDX_W - 1;

  logic [DATA_W-1:0] word;
  logic [IDX_W-1:0]  idx;

  assign idx = addr_i[ADDR_W-1:1];

  always_comb begin
    word = '0;
    if (idx[IDX_W-1]) begin
      word = words_i[idx[WIN_W-1:0]];
    end else if (idx == IDX_W'(fx_pkg::FX_IDX_COLOR)) begin
      word = DATA_W'(color_i);
    end else if (idx == IDX_W'(fx_pkg::FX_IDX_FONT)) begin
      word = font_i;
    end
  end

  always_comb begin
    if (byte_i) begin
      rd_data_o = DATA_W'(addr_i[0] ? word[HALF-1:0] : word[DATA_W-1:HALF]);
    end else begin
      rd_data_o = word;
    end
  end
endmodule

// File: rtl/font_expander.sv
module font_expander #(
  parameter int unsigned ADDR_W = fx_pkg::FX_ADDR_W,
  parameter int unsigned DATA_W = fx_pkg::FX_DATA_W,
  parameter int unsigned COL_W  = fx_pkg::FX_COL_W,
  parameter int unsigned NIB_W  = fx_pkg::FX_NIB_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              byte_i,
  input  logic              wr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rd_data_o
);
  localparam int unsigned GRP_W = DATA_W / NIB_W;
  localparam int unsigned N_GRP = DATA_W / GRP_W;
  localparam int unsigned HALF  = DATA_W / 2;

  logic [COL_W-1:0]  color_q;
  logic [DATA_W-1:0] font_q;
  logic [N_GRP-1:0][DATA_W-1:0] words;

  fx_regs #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .COL_W(COL_W)) u_regs (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .addr_i  (addr_i),
    .byte_i  (byte_i),
    .wr_i    (wr_i),
    .wdata_i (wdata_i),
    .color_o (color_q),
    .font_o  (font_q)
  );

  fx_expand #(.DATA_W(DATA_W), .COL_W(COL_W), .NIB_W(NIB_W)) u_expand (
    .color_i (color_q),
    .font_i  (font_q),
    .words_o (words)
  );

  fx_rdmux #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .COL_W(COL_W), .N_GRP(N_GRP)) u_rdmux (
    .addr_i    (addr_i),
    .byte_i    (byte_i),
    .color_i   (color_q),
    .font_i    (font_q),
    .words_i   (words),
    .rd_data_o (rd_data_o)
  );

  // every pixel is one of the two programmed colours
  for (genvar k = 0; k < N_GRP; k++) begin : g_chk_w
    for (genvar j = 0; j < GRP_W; j++) begin : g_chk_p
      a_r2_pixel_from_pair: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (words[k][j*NIB_W +: NIB_W] == color_q[COL_W-1 -: NIB_W]) ||
        (words[k][j*NIB_W +: NIB_W] == color_q[NIB_W-1:0]));
    end
  end

  a_r5_byte_read_upper_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    byte_i |-> (rd_data_o[DATA_W-1:HALF] == '0));

  a_r1_zero_after_reset: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(rst_ni) |-> (rd_data_o == '0));
endmodule

// File: tb/font_expander_tb.sv
module font_expander_tb;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [3:0]  addr_i = '0;
  logic        byte_i = 1'b0;
  logic        wr_i = 1'b0;
  logic [15:0] wdata_i = '0;
  logic [15:0] rd_data_o;

  int n_run = 0;
  int n_fail = 0;
  logic [15:0] exp_q[$];
  string       tag_q[$];
  logic [7:0]  m_col = '0;
  logic [15:0] m_font = '0;
  bit          done = 1'b0;

  always #2.5 clk_i = ~clk_i;

  font_expander u_dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .addr_i(addr_i), .byte_i(byte_i),
    .wr_i(wr_i), .wdata_i(wdata_i), .rd_data_o(rd_data_o)
  );

  function automatic logic [15:0] model_word(input logic [3:0] a);
    logic [2:0]  idx;
    logic [15:0] w;
    logic [3:0]  g;
    int          k;
    idx = a[3:1];
    w = '0;
    if (idx == 3'd0) w = {8'h00, m_col};
    else if (idx == 3'd1) w = m_font;
    else if (idx >= 3'd4) begin
      k = int'(idx) - 4;
      g = 4'((m_font >> (12 - 4*k)) & 16'hF);
      for (int j = 0; j < 4; j++) w[4*j +: 4] = g[j] ? m_col[7:4] : m_col[3:0];
    end
    return w;
  endfunction

  function automatic logic [15:0] model_rd(input logic [3:0] a, input logic b);
    logic [15:0] w;
    w = model_word(a);
    if (!b) return w;
    return a[0] ? {8'h00, w[7:0]} : {8'h00, w[15:8]};
  endfunction

  task automatic do_wr(input logic [3:0] a, input logic b, input logic [15:0] d);
    @(negedge clk_i);
    addr_i = a; byte_i = b; wdata_i = d; wr_i = 1'b1;
    if (a[3] == 1'b0) begin
      if (a[2:1] == 2'd0 && (!b || a[0])) m_col = d[7:0];
      if (a[2:1] == 2'd1) begin
        if (!b) m_font = d;
        else if (a[0]) m_font[7:0] = d[7:0];
        else m_font[15:8] = d[7:0];
      end
    end
    @(negedge clk_i);
    wr_i = 1'b0;
  endtask

  task automatic do_rd(input logic [3:0] a, input logic b, input string tag);
    @(negedge clk_i);
    addr_i = a; byte_i = b; wr_i = 1'b0;
    exp_q.push_back(model_rd(a, b));
    tag_q.push_back(tag);
  endtask

  // monitor: compares one queued item per cycle just after the rising edge
  initial begin
    forever begin
      @(posedge clk_i);
      #1;
      if (exp_q.size() > 0) begin
        logic [15:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        n_run++;
        if (rd_data_o !== e) begin
          n_fail++;
          $display("FAIL %s addr=%h byte=%0b actual=%h expected=%h", t, addr_i, byte_i, rd_data_o, e);
        end
      end
    end
  end

  task automatic rd_all(input string tag);
    for (int a = 0; a < 16; a += 2) do_rd(4'(a), 1'b0, tag);
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    rd_all("R1 reset");
    // R2 R3 R4: distinct patterns
    do_wr(4'h0, 1'b0, 16'h00A5);
    do_wr(4'h2, 1'b0, 16'h8421);
    rd_all("R3 R4 one-hot groups");
    do_wr(4'h2, 1'b0, 16'hF00F);
    rd_all("R2 solid groups");
    do_wr(4'h0, 1'b0, 16'hFF3C);
    do_wr(4'h2, 1'b0, 16'h1E7B);
    // R7: read right after write
    do_rd(4'h8, 1'b0, "R7 immediate");
    do_rd(4'hE, 1'b0, "R4 lowest group");
    rd_all("R2 mixed");
    // R5 byte reads
    for (int a = 0; a < 16; a++) do_rd(4'(a), 1'b1, "R5 byte read");
    // R6 window writes
    do_wr(4'h8, 1'b0, 16'hFFFF);
    do_wr(4'hB, 1'b1, 16'h0055);
    do_wr(4'hE, 1'b0, 16'h1234);
    do_rd(4'h0, 1'b0, "R6 color kept");
    do_rd(4'h2, 1'b0, "R6 font kept");
    // R8 byte writes
    do_wr(4'h0, 1'b1, 16'h0099);
    do_rd(4'h0, 1'b0, "R8 byte0 ignored");
    do_wr(4'h1, 1'b1, 16'h1296);
    do_wr(4'h2, 1'b1, 16'h00C3);
    do_rd(4'h2, 1'b0, "R8 font hi byte");
    do_wr(4'h3, 1'b1, 16'hAA5A);
    do_rd(4'h2, 1'b0, "R8 font lo byte");
    do_rd(4'h0, 1'b0, "R8 color byte");
    rd_all("R8 expansion after byte writes");
    // R9 unmapped
    do_wr(4'h4, 1'b0, 16'hBEEF);
    do_wr(4'h7, 1'b1, 16'h00EE);
    do_rd(4'h4, 1'b0, "R9 unmapped 4");
    do_rd(4'h6, 1'b0, "R9 unmapped 6");
    do_rd(4'h2, 1'b0, "R9 font kept");
    do_rd(4'h0, 1'b0, "R9 color kept");
    // R1 again via async reset
    @(negedge clk_i);
    rst_ni = 1'b0;
    m_col = '0; m_font = '0;
    @(negedge clk_i);
    rst_ni = 1'b1;
    rd_all("R1 second reset");
    repeat (3) @(negedge clk_i);
    done = 1'b1;
  end

  initial begin
    int cyc = 0;
    while (!done && cyc < 5000) begin
      @(posedge clk_i);
      cyc++;
    end
    if (!done) begin
      n_run++;
      n_fail++;
      $display("FAIL watchdog actual=%0d expected<5000", cyc);
    end
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule